// File: doc/BRIEF.md
# Staged Serial-to-Parallel Shifter

This block turns a serial bit stream into a parallel word in two steps. Each rising edge of the shift clock moves a new bit into a chain of stages. A separate rising edge of the capture clock copies the whole chain into a holding bank, and only the holding bank drives the parallel outputs. As a result, the outputs stay steady while new data ripples through the chain, and they change in one step once the word is complete.

Each of the two registers has its own active-low asynchronous clear. A serial cascade output taken from the last chain stage allows several blocks to be linked into one longer chain. The two clocks may be driven from a single net. In that case, each capture records the chain contents from before that same edge's shift.

Top module: `sipo_staged_shifter`

## Requirements
- R1: On each rising edge of `shift_clk`, chain stage 0 takes `ser_in`, and each stage k>0 takes the former value of stage k-1. With no rising edge, the chain holds its value.
- R2: On each rising edge of `store_clk` while `store_clr_n` is high, `par_out` takes the full chain contents, with bit k equal to stage k. Between such edges, `par_out` holds its value, even while the chain shifts.
- R3: While `shift_clr_n` is low, every chain stage is 0 at once, and shift edges that arrive during the clear are ignored.
- R4: While `store_clr_n` is low, `par_out` is all zeros at once, and capture edges that arrive during the clear are ignored. This clear leaves the chain untouched, and the chain clear leaves `par_out` untouched.
- R5: `cascade_out` always equals the last chain stage (bit WIDTH-1), never the holding bank.
- R6: When both clocks rise together, `par_out` receives the chain value from before that edge's shift, so it trails the chain by exactly one pulse.
- R7: A chain clear followed by a capture edge loads all zeros into `par_out`.
- R8: Two blocks linked from `cascade_out` to `ser_in`, sharing clocks, behave as one 2×WIDTH-stage chain. The downstream block holds bits WIDTH to 2×WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Chain clock, rising edge |
| shift_clr_n | input | 1 | Chain clear, active low, asynchronous |
| ser_in | input | 1 | Serial data into stage 0 |
| store_clk | input | 1 | Capture clock, rising edge |
| store_clr_n | input | 1 | Holding bank clear, active low, asynchronous |
| par_out | output | WIDTH | Holding bank contents; bit 0 is stage 0 |
| cascade_out | output | 1 | Last chain stage, for linking blocks |

## Verification
The chain is visible at the ports only through `cascade_out`. A wrong stage value therefore shows up there after the number of shift pulses between that stage and the end of the chain, or at once in `par_out` on the next capture edge. A capture that takes the post-shift value, or a clear that reaches the wrong register, shows up in `par_out` on the very next capture edge. For this reason, the reference model is compared against both outputs of both linked blocks on every bench clock.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    // Level of an active-low clear input
    typedef enum logic {
        CLR_ACTIVE = 1'b0,
        CLR_IDLE   = 1'b1
    } clr_level_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain
    import sipo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    generate
        if (WIDTH == 1) begin : g_single
            always_comb begin
                chain_d      = chain_q;
                chain_d.bits = ser_in;
            end
        end else begin : g_multi
            always_comb begin
                chain_d      = chain_q;
                chain_d.bits = {chain_q.bits[WIDTH-2:0], ser_in};
            end

            AST_STAGES_ADVANCE: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
                1'b1 |=> chain_q.bits[WIDTH-1:1] == $past(chain_q.bits[WIDTH-2:0])); // R1
        end
    endgenerate

    always_ff @(posedge shift_clk or negedge shift_clr_n) begin
        if (shift_clr_n == CLR_ACTIVE) chain_q <= '0;
        else                           chain_q <= chain_d;
    end

    assign stages = chain_q.bits;

    AST_STAGE0_LOADS_SERIAL: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        1'b1 |=> chain_q.bits[0] == $past(ser_in)); // R1
    AST_CHAIN_CLEAR_ZERO: assert property (@(posedge shift_clk)
        !shift_clr_n |-> chain_q.bits == '0); // R3
endmodule

// File: rtl/sipo_hold_bank.sv
module sipo_hold_bank
    import sipo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             store_clk,
    input  logic             store_clr_n,
    input  logic [WIDTH-1:0] capture_in,
    output logic [WIDTH-1:0] held
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.word = capture_in;
    end

    always_ff @(posedge store_clk or negedge store_clr_n) begin
        if (store_clr_n == CLR_ACTIVE) bank_q <= '0;
        else                           bank_q <= bank_d;
    end

    assign held = bank_q.word;

    AST_CAPTURE_PRE_EDGE: assert property (@(posedge store_clk) disable iff (!store_clr_n)
        1'b1 |=> bank_q.word == $past(capture_in)); // R2
    AST_BANK_CLEAR_ZERO: assert property (@(posedge store_clk)
        !store_clr_n |-> bank_q.word == '0); // R4
endmodule

// File: rtl/sipo_staged_shifter.sv
module sipo_staged_shifter
    import sipo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             ser_in,
    input  logic             store_clk,
    input  logic             store_clr_n,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] stage_bits;

    sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .shift_clk   (shift_clk),
        .shift_clr_n (shift_clr_n),
        .ser_in      (ser_in),
        .stages      (stage_bits)
    );

    sipo_hold_bank #(.WIDTH(WIDTH)) u_bank (
        .store_clk   (store_clk),
        .store_clr_n (store_clr_n),
        .capture_in  (stage_bits),
        .held        (par_out)
    );

    assign cascade_out = stage_bits[LAST];

    generate
        if (WIDTH > 1) begin : g_casc_chk
            AST_CASCADE_FOLLOWS: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
                1'b1 |=> cascade_out == $past(stage_bits[LAST-1])); // R5
        end else begin : g_casc_chk1
            AST_CASCADE_FOLLOWS: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
                1'b1 |=> cascade_out == $past(ser_in)); // R5
        end
    endgenerate
endmodule

// File: tb/sim_sipo_staged_shifter.sv
module sim_sipo_staged_shifter;
    localparam int W = 8;
    localparam int L = 2 * W;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic sclk = 1'b0, lclk = 1'b0, sclr_n = 1'b0, lclr_n = 1'b0, din = 1'b0;
    logic [W-1:0] pout_a, pout_b;
    logic casc_a, casc_b;

    sipo_staged_shifter #(.WIDTH(W)) u0 (
        .shift_clk(sclk), .shift_clr_n(sclr_n), .ser_in(din),
        .store_clk(lclk), .store_clr_n(lclr_n),
        .par_out(pout_a), .cascade_out(casc_a));

    sipo_staged_shifter #(.WIDTH(W)) u1 (
        .shift_clk(sclk), .shift_clr_n(sclr_n), .ser_in(casc_a),
        .store_clk(lclk), .store_clr_n(lclr_n),
        .par_out(pout_b), .cascade_out(casc_b));

    // Reference model: one long chain as a bit queue, index 0 = first stage
    bit mq[$];
    logic [L-1:0] held_m;
    int checks = 0, failures = 0;
    string phase = "R3";
    bit running = 1'b0;

    function automatic void m_shift(bit d);
        if (sclr_n) begin mq.push_front(d); void'(mq.pop_back()); end
    endfunction
    function automatic void m_store();
        if (lclr_n) for (int i = 0; i < L; i++) held_m[i] = mq[i];
    endfunction

    task automatic cmp(string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) if (running) begin
        cmp("par_out_a", pout_a, held_m[W-1:0]);
        cmp("par_out_b", pout_b, held_m[L-1:W]);
        cmp("cascade_a(R5)", {{(W-1){1'b0}}, casc_a}, {{(W-1){1'b0}}, mq[W-1]});
        cmp("cascade_b(R5)", {{(W-1){1'b0}}, casc_b}, {{(W-1){1'b0}}, mq[L-1]});
    end

    task automatic shift1(bit d);
        din = d;
        @(negedge clk); sclk = 1'b1; m_shift(d);
        @(negedge clk); sclk = 1'b0;
    endtask
    task automatic store1();
        @(negedge clk); lclk = 1'b1; m_store();
        @(negedge clk); lclk = 1'b0;
    endtask
    task automatic both1(bit d);
        din = d;
        @(negedge clk); sclk = 1'b1; lclk = 1'b1; m_store(); m_shift(d);
        @(negedge clk); sclk = 1'b0; lclk = 1'b0;
    endtask
    task automatic shift_word(logic [L-1:0] v, int n);
        for (int i = n - 1; i >= 0; i--) shift1(v[i]);
    endtask

    task automatic run();
        for (int i = 0; i < L; i++) mq.push_back(1'b0);
        held_m = '0;
        running = 1'b1;
        // Reset state, R3 / R4
        phase = "R3";
        repeat (3) @(negedge clk);
        sclr_n = 1'b1; lclr_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: shifting, hold without edges
        phase = "R1";
        shift_word(16'h00B5, W);
        repeat (3) @(negedge clk);
        // R2: capture, then holds while chain moves
        phase = "R2";
        store1();
        shift_word(16'h0036, 5);
        repeat (2) @(negedge clk);
        store1();
        // R6: tied clocks
        phase = "R6";
        for (int i = 0; i < 10; i++) both1(1'((i * 5 + 1) % 3 == 0));
        both1(1'b1); both1(1'b0);
        // R4: storage clear mid-sequence, chain undisturbed
        phase = "R4";
        @(negedge clk); lclr_n = 1'b0; held_m = '0;
        shift_word(16'h0005, 3);
        store1();
        @(negedge clk); lclr_n = 1'b1;
        @(negedge clk);
        store1();
        // R3: chain clear, edges during clear ignored, bank kept
        phase = "R3";
        @(negedge clk); sclr_n = 1'b0;
        foreach (mq[i]) mq[i] = 1'b0;
        shift1(1'b1); shift1(1'b1);
        @(negedge clk); sclr_n = 1'b1;
        repeat (2) @(negedge clk);
        // R7: capture after chain clear yields zeros
        phase = "R7";
        store1();
        // R8: two linked blocks carry a 2W pattern
        phase = "R8";
        shift_word(16'hC3A5, L);
        store1();
        shift_word(16'h5A1E, L);
        both1(1'b1);
        // Mixed traffic, R1 R2 R6
        phase = "R1";
        for (int i = 0; i < 200; i++) begin
            int op = (i * 7 + 3) % 5;
            bit d = 1'((i * 13 + 1) % 3 == 1);
            if (op < 3) shift1(d);
            else if (op == 3) store1();
            else both1(d);
        end
        repeat (2) @(negedge clk);
        running = 1'b0;
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired phase=%s actual=hung expected=done", phase);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule